// File: doc/BRIEF.md
# Endpoint-0 Receive Handshake Controller

This block sits between a USB serial interface engine and the CPU for a device's control endpoint. For every OUT or SETUP transaction addressed to endpoint 0 it chooses the handshake (ACK, NAK, STALL or none). It records the received data toggle and keeps error, overwrite and full flags for the receive buffer. Software reaches a status register and a control-transfer register through a small byte-wide port.

The serial engine signals a decoded SETUP or OUT token with a one-cycle pulse. It later pulses `pkt_end` when the data packet ends, with the packet's toggle and its CRC and bit-stuff error indications valid in that same cycle. The handshake comes out as a one-cycle strobe with a 2-bit code in the cycle after `pkt_end`. Software can arm the block so that it sets both stall bits itself once the status stage of a control transfer completes. That status stage is either an accepted OUT packet, optionally restricted to DATA1, or a finished IN transaction. The transmit side's stall bit lives elsewhere, so this block drives a set strobe for it.

Top module: `ep0_rx_handshake`

## Requirements
- R1: One clock after a `pkt_end` that closes a pending SETUP or OUT transaction, `hs_valid` is high for exactly one cycle with `hs_code` 00 none, 01 ACK, 10 NAK, 11 STALL. `hs_code` is 00 whenever `hs_valid` is low. A `pkt_end` with no pending transaction is ignored.
- R2: A packet with `crc_err` or `stuff_err` high at `pkt_end` gets code 00 and sets the error flag (status bit 5). A CPU write of 0 to bit 5 clears the flag and a write of 1 leaves it as it is.
- R3: An error-free SETUP packet is always answered ACK and sets the full flag, whatever the NAK and stall bits hold. If the full flag was already set, it also sets the read-only overwrite flag (status bit 4). The overwrite flag clears when software clears the full flag.
- R4: The read-only toggle bit (status bit 3) takes the packet's `pid_data1` value at every error-free SETUP or OUT packet, whatever handshake is returned.
- R5: For an error-free OUT packet the handshake follows this priority. STALL if the receive stall bit (status bit 1) is set. Otherwise NAK if the OUT-NAK bit (status bit 2) is set or the full flag is set. Otherwise ACK. Both bits are read/write, and `rx_stall` mirrors bit 1.
- R6: The full flag (status bit 0) is set by every ACKed SETUP or OUT packet. A CPU write of 0 clears it and a write of 1 has no effect. If a hardware set and a CPU clear fall in the same cycle, the set wins.
- R7: When control bit 1 is set, an ACKed OUT packet sets the receive stall bit and pulses `tx_stall_set` in the same cycle as the handshake. When control bit 2 is also set, only a DATA1 packet (`pid_data1`=1) triggers this.
- R8: When control bit 0 is set, an `in_done` pulse sets the receive stall bit and pulses `tx_stall_set` one clock later.
- R9: A SETUP token clears the control register (bits 2:0), overriding a CPU write in the same cycle.
- R10: `rst_n` low or a `bus_rst` pulse clears every flag, control bit, pending transaction and output strobe. `cpu_rdata` shows the status register when `cpu_sel`=0 and the control register when `cpu_sel`=1, with unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | USB bus reset, synchronous, active high |
| tok_setup | input | 1 | SETUP token for endpoint 0 decoded (pulse) |
| tok_out | input | 1 | OUT token for endpoint 0 decoded (pulse) |
| in_done | input | 1 | IN transaction on endpoint 0 completed (pulse) |
| pkt_end | input | 1 | End of the data packet (pulse) |
| pid_data1 | input | 1 | Data packet is DATA1, valid with `pkt_end` |
| crc_err | input | 1 | CRC error on the data packet, valid with `pkt_end` |
| stuff_err | input | 1 | Bit-stuff error on the data packet, valid with `pkt_end` |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel | input | 1 | Register select: 0 status, 1 control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | Handshake code |
| rx_stall | output | 1 | Receive stall bit |
| tx_stall_set | output | 1 | Strobe that sets the transmit stall bit |

## Verification
The assertions assume that the engine's stimulus keeps transactions apart. A token pulse never falls in the same cycle as `pkt_end`, at least one cycle separates them, and each transaction finishes before the next token arrives. Error and toggle inputs matter only in the `pkt_end` cycle. The bench meets these assumptions by running every SETUP or OUT as one fixed sequence: token, one idle cycle, `pkt_end`, one idle cycle. CPU writes, `in_done` and bus resets are issued only between transactions.

// File: rtl/ep0_rx_handshake.sv
module ep0_rx_handshake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       tok_setup,
  input  logic       tok_out,
  input  logic       in_done,
  input  logic       pkt_end,
  input  logic       pid_data1,
  input  logic       crc_err,
  input  logic       stuff_err,
  input  logic       cpu_wr,
  input  logic       cpu_sel,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  output logic       rx_stall,
  output logic       tx_stall_set
);

  localparam logic [1:0] HS_NONE  = 2'b00;
  localparam logic [1:0] HS_ACK   = 2'b01;
  localparam logic [1:0] HS_NAK   = 2'b10;
  localparam logic [1:0] HS_STALL = 2'b11;

  localparam logic [1:0] K_IDLE  = 2'd0;
  localparam logic [1:0] K_OUT   = 2'd1;
  localparam logic [1:0] K_SETUP = 2'd2;

  logic       err_q, ovw_q, tog_q, nak_q, stall_q, full_q;
  logic [2:0] ctl_q;
  logic [1:0] kind_q;

  logic       pkt_bad, fin, fin_ok, is_setup;
  logic [1:0] code;
  logic       acked, auto_out, auto_in;
  logic       st_wr, ct_wr;

  assign pkt_bad  = crc_err | stuff_err;
  assign fin      = pkt_end && (kind_q != K_IDLE);
  assign fin_ok   = fin && !pkt_bad;
  assign is_setup = (kind_q == K_SETUP);
  assign st_wr    = cpu_wr && !cpu_sel;
  assign ct_wr    = cpu_wr && cpu_sel;

  always_comb begin
    if (pkt_bad)              code = HS_NONE;
    else if (is_setup)        code = HS_ACK;
    else if (stall_q)         code = HS_STALL;
    else if (nak_q || full_q) code = HS_NAK;
    else                      code = HS_ACK;
  end

  assign acked    = fin_ok && (code == HS_ACK);
  assign auto_out = acked && !is_setup && ctl_q[1] && (!ctl_q[2] || pid_data1);
  assign auto_in  = in_done && ctl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0; ovw_q <= 1'b0; tog_q <= 1'b0;
      nak_q <= 1'b0; stall_q <= 1'b0; full_q <= 1'b0;
      ctl_q <= '0; kind_q <= K_IDLE;
      hs_valid <= 1'b0; hs_code <= HS_NONE; tx_stall_set <= 1'b0;
    end else if (bus_rst) begin
      err_q <= 1'b0; ovw_q <= 1'b0; tog_q <= 1'b0;
      nak_q <= 1'b0; stall_q <= 1'b0; full_q <= 1'b0;
      ctl_q <= '0; kind_q <= K_IDLE;
      hs_valid <= 1'b0; hs_code <= HS_NONE; tx_stall_set <= 1'b0;
    end else begin
      hs_valid     <= fin;
      hs_code      <= fin ? code : HS_NONE;
      tx_stall_set <= auto_out || auto_in;

      if (fin && pkt_bad)                err_q <= 1'b1;
      else if (st_wr && !cpu_wdata[5])   err_q <= 1'b0;

      if (acked)                         full_q <= 1'b1;
      else if (st_wr && !cpu_wdata[0])   full_q <= 1'b0;

      if (fin_ok && is_setup && full_q)  ovw_q <= 1'b1;
      else if (st_wr && !cpu_wdata[0])   ovw_q <= 1'b0;

      if (fin_ok)                        tog_q <= pid_data1;

      if (st_wr)                         nak_q <= cpu_wdata[2];

      if (auto_out || auto_in)           stall_q <= 1'b1;
      else if (st_wr)                    stall_q <= cpu_wdata[1];

      if (tok_setup)                     ctl_q <= '0;
      else if (ct_wr)                    ctl_q <= cpu_wdata[2:0];

      if (tok_setup)                     kind_q <= K_SETUP;
      else if (tok_out)                  kind_q <= K_OUT;
      else if (pkt_end)                  kind_q <= K_IDLE;
    end
  end

  assign rx_stall  = stall_q;
  assign cpu_rdata = cpu_sel ? {5'b0, ctl_q}
                             : {2'b0, err_q, ovw_q, tog_q, nak_q, stall_q, full_q};

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid); // R1
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_valid |-> hs_code == HS_NONE); // R1
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(crc_err || stuff_err)) |-> (hs_code == HS_NONE && err_q)); // R2
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(kind_q == K_SETUP && !(crc_err || stuff_err))) |-> (hs_code == HS_ACK && full_q)); // R3
  AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(kind_q == K_OUT && stall_q && !(crc_err || stuff_err))) |-> hs_code == HS_STALL); // R5
  AST_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_ACK) |-> full_q); // R6
  AST_TX_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall_set |-> rx_stall); // R7
  AST_BUS_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rst) |-> (!hs_valid && !tx_stall_set && !err_q && !full_q && !ovw_q && !stall_q && ctl_q == 3'b0)); // R10

endmodule

// File: tb/ep0_rx_handshake_tb.sv
`timescale 1ns/1ps
module ep0_rx_handshake_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0;
  logic tok_setup = 1'b0, tok_out = 1'b0, in_done = 1'b0;
  logic pkt_end = 1'b0, pid_data1 = 1'b0, crc_err = 1'b0, stuff_err = 1'b0;
  logic cpu_wr = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic hs_valid, rx_stall, tx_stall_set;
  logic [1:0] hs_code;

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  logic       last_v, last_tx;
  logic [1:0] last_c;

  ep0_rx_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .tok_setup(tok_setup), .tok_out(tok_out), .in_done(in_done),
    .pkt_end(pkt_end), .pid_data1(pid_data1), .crc_err(crc_err), .stuff_err(stuff_err),
    .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hs_valid(hs_valid), .hs_code(hs_code),
    .rx_stall(rx_stall), .tx_stall_set(tx_stall_set)
  );

  always #2 clk = ~clk;

  // behavioural reference
  bit m_err, m_ovw, m_tog, m_nak, m_stall, m_full, m_hsv, m_tx;
  bit [2:0] m_ctl;
  bit [1:0] m_hsc;
  int m_kind = 0; // 0 idle, 1 out, 2 setup

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || bus_rst) begin
      {m_err, m_ovw, m_tog, m_nak, m_stall, m_full, m_hsv, m_tx} = '0;
      m_ctl = 0; m_hsc = 0; m_kind = 0;
    end else begin
      bit o_full, o_stall, o_nak, bad_pkt;
      bit [2:0] o_ctl;
      int o_kind;
      o_full = m_full; o_stall = m_stall; o_nak = m_nak; o_ctl = m_ctl; o_kind = m_kind;
      m_hsv = 0; m_hsc = 0; m_tx = 0;
      if (cpu_wr && !cpu_sel) begin
        if (!cpu_wdata[5]) m_err = 0;
        m_nak = cpu_wdata[2];
        m_stall = cpu_wdata[1];
        if (!cpu_wdata[0]) begin m_full = 0; m_ovw = 0; end
      end
      if (cpu_wr && cpu_sel) m_ctl = cpu_wdata[2:0];
      if (tok_setup) m_ctl = 0;
      if (pkt_end) m_kind = 0;
      if (tok_setup) m_kind = 2; else if (tok_out) m_kind = 1;
      if (pkt_end && o_kind != 0) begin
        m_hsv = 1;
        bad_pkt = crc_err || stuff_err;
        if (bad_pkt) begin
          m_err = 1; m_hsc = 0;
        end else begin
          m_tog = pid_data1;
          if (o_kind == 2) begin
            m_hsc = 1;
            if (o_full) m_ovw = 1;
            m_full = 1;
          end else if (o_stall) m_hsc = 3;
          else if (o_nak || o_full) m_hsc = 2;
          else begin
            m_hsc = 1; m_full = 1;
            if (o_ctl[1] && (!o_ctl[2] || pid_data1)) begin m_stall = 1; m_tx = 1; end
          end
        end
      end
      if (in_done && o_ctl[0]) begin m_stall = 1; m_tx = 1; end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      chk({7'b0, hs_valid}, {7'b0, m_hsv}, "R1 hs_valid");
      chk({6'b0, hs_code}, {6'b0, m_hsc}, "R1 hs_code");
      chk({7'b0, tx_stall_set}, {7'b0, m_tx}, "R7 tx_stall_set");
      chk({7'b0, rx_stall}, {7'b0, m_stall}, "R5 rx_stall");
      if (!cpu_sel) begin
        chk({7'b0, cpu_rdata[5]}, {7'b0, m_err}, "R2 error flag");
        chk({7'b0, cpu_rdata[4]}, {7'b0, m_ovw}, "R3 overwrite flag");
        chk({7'b0, cpu_rdata[3]}, {7'b0, m_tog}, "R4 toggle");
        chk({6'b0, cpu_rdata[2:1]}, {6'b0, m_nak, m_stall}, "R5 nak/stall bits");
        chk({7'b0, cpu_rdata[0]}, {7'b0, m_full}, "R6 full flag");
        chk({6'b0, cpu_rdata[7:6]}, 8'h00, "R10 unused status bits");
      end else begin
        chk(cpu_rdata, {5'b0, m_ctl}, "R9 control register");
      end
    end
  end

  task automatic xact(input bit setup, input bit pid, input bit ce, input bit se);
    @(negedge clk); tok_setup = setup; tok_out = !setup;
    @(negedge clk); tok_setup = 0; tok_out = 0;
    @(negedge clk); pkt_end = 1; pid_data1 = pid; crc_err = ce; stuff_err = se;
    @(negedge clk); pkt_end = 0; crc_err = 0; stuff_err = 0; pid_data1 = 0;
    #1; last_v = hs_valid; last_c = hs_code; last_tx = tx_stall_set;
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0; cpu_sel = 0;
  endtask

  task automatic pulse_in();
    @(negedge clk); in_done = 1;
    @(negedge clk); in_done = 0;
    #1; last_tx = tx_stall_set;
  endtask

  task automatic rd(input bit sel, input logic [7:0] exp, input string tag);
    @(negedge clk); cpu_sel = sel;
    #1; chk(cpu_rdata, exp, tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    rd(0, 8'h00, "R10 status after reset");
    rd(1, 8'h00, "R10 control after reset");
    chk({7'b0, hs_valid}, 8'h00, "R10 no strobe after reset");

    xact(0, 0, 0, 0);
    chk({6'b0, last_v, last_c[0]}, 8'h03, "R1 ACK strobe");
    chk({6'b0, last_c}, 8'h01, "R5 empty OUT ACK");
    rd(0, 8'h01, "R6 full after ACK");
    xact(0, 1, 0, 0);
    chk({6'b0, last_c}, 8'h02, "R5 full OUT NAK");
    rd(0, 8'h09, "R4 toggle from NAKed OUT");
    wr(0, 8'h21);
    rd(0, 8'h09, "R6 write one keeps full");
    wr(0, 8'h00);
    rd(0, 8'h08, "R6 write zero clears full");

    xact(0, 0, 1, 0);
    chk({6'b0, last_v, last_c[0]}, 8'h02, "R2 CRC error silent");
    rd(0, 8'h28, "R2 error flag set, toggle kept");
    wr(0, 8'h20);
    rd(0, 8'h28, "R2 write one keeps error");
    wr(0, 8'h00);
    rd(0, 8'h08, "R2 write zero clears error");

    wr(0, 8'h04);
    xact(0, 0, 0, 0);
    chk({6'b0, last_c}, 8'h02, "R5 NAK bit");
    rd(0, 8'h04, "R5 NAK leaves full clear");
    wr(0, 8'h06);
    xact(0, 1, 0, 0);
    chk({6'b0, last_c}, 8'h03, "R5 stall before NAK");
    rd(0, 8'h0E, "R5 stall status");

    xact(1, 0, 0, 0);
    chk({6'b0, last_c}, 8'h01, "R3 SETUP ACK over stall");
    rd(0, 8'h07, "R3 SETUP sets full");
    xact(1, 1, 0, 1);
    chk({6'b0, last_v, last_c[0]}, 8'h02, "R2 stuff error silent");
    rd(0, 8'h27, "R2 stuff error flag");
    xact(1, 0, 0, 0);
    chk({6'b0, last_c}, 8'h01, "R3 SETUP ACK when full");
    rd(0, 8'h37, "R3 overwrite flag");
    wr(0, 8'h00);
    rd(0, 8'h00, "R3 overwrite clears with full");

    wr(1, 8'h06);
    xact(0, 0, 0, 0);
    chk({7'b0, last_tx}, 8'h00, "R7 DATA0 ignored when DATA1-only");
    rd(0, 8'h01, "R7 no stall on DATA0");
    wr(0, 8'h00);
    xact(0, 1, 0, 0);
    chk({7'b0, last_tx}, 8'h01, "R7 auto stall strobe");
    rd(0, 8'h0B, "R7 auto stall bit");
    rd(1, 8'h06, "R7 control kept");

    wr(0, 8'h00);
    wr(1, 8'h01);
    pulse_in();
    chk({7'b0, last_tx}, 8'h01, "R8 IN auto stall strobe");
    rd(0, 8'h0A, "R8 IN auto stall bit");

    wr(1, 8'h07);
    xact(1, 0, 0, 0);
    rd(1, 8'h00, "R9 SETUP clears control");

    @(negedge clk); bus_rst = 1;
    @(negedge clk); bus_rst = 0;
    rd(0, 8'h00, "R10 bus reset status");
    rd(1, 8'h00, "R10 bus reset control");

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: xact(0, 1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        3:       xact(1, 1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        4:       pulse_in();
        5, 6:    wr(0, 8'($urandom));
        7:       wr(1, 8'($urandom));
        8:       begin @(negedge clk); cpu_sel = ~cpu_sel; end
        default: if ($urandom_range(0, 15) == 0) begin
                   @(negedge clk); bus_rst = 1;
                   @(negedge clk); bus_rst = 0;
                 end
      endcase
    end

    wr(1, 8'h05);
    wr(0, 8'h26);
    @(negedge clk); rst_n = 0;
    @(negedge clk); #1;
    cpu_sel = 0; #0.5;
    chk(cpu_rdata, 8'h00, "R10 hardware reset status");
    cpu_sel = 1; #0.5;
    chk(cpu_rdata, 8'h00, "R10 hardware reset control");
    @(negedge clk); rst_n = 1; cpu_sel = 0;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule